// File: doc/BRIEF.md
# Prescaler Timer with Watchdog

This block is a free-running binary counter driven by the main clock. Software can zero it with a clear command. One of six power-of-two divided outputs is selected, from the counter's bit 10 up to bit 15 in the default 17-bit build. A 4-bit read value exposes the top nibble below the watchdog bit. A mode bit picks one of two views. In the full view, all four bits 15..12 are returned. In the coarse view, only bit 15 is returned in the MSB position and the three lower bits read as zero.

The same counter serves two more purposes. When the watchdog is enabled, the counter must be cleared before it reaches 2^16. Otherwise a one-cycle reset pulse is issued and counting restarts from zero. While the core is in the power-save hold state the counter is frozen. On release from hold the counter restarts from zero and an oscillator-stabilisation wait runs. During that wait the ready output stays low until the count reaches 2^16, and the watchdog cannot fire.

Top module: `presc_wdt_timer`

## Requirements
- R1: Synchronous active-high reset sets the following state: counter zero, control word zero, `wdt_rst` low, `ready` high. Both `rd_nibble` and `tap_out` then read zero.
- R2: While `hold` is low and no other rule applies, the counter advances by one every clock and wraps modulo 2^CNT_W.
- R3: With `hold` low, `clr` zeroes the counter at the next edge. A watchdog pulse that would have fired at that edge is suppressed.
- R4: Control bits [2:0] select the divided output. A value v from 0 to 5 drives `tap_out` from counter bit CNT_W-7+v. Values 6 and 7 select bit CNT_W-2.
- R5: With control bit 3 set, `rd_nibble` equals counter bits CNT_W-2 down to CNT_W-5, with bit CNT_W-2 in the MSB.
- R6: With control bit 3 clear, `rd_nibble` is {counter bit CNT_W-2, 3'b000}.
- R7: The watchdog is enabled by control bit 4. Suppose the counter holds 2^(CNT_W-1) while the watchdog is enabled, no stabilisation wait is running, `hold` is low and `clr` is low. Then `wdt_rst` is high for exactly the next cycle and the counter restarts at 0.
- R8: With control bit 4 clear, reaching 2^(CNT_W-1) produces no pulse and counting continues.
- R9: While `hold` is high, the counter is frozen and `clr` has no effect.
- R10: The first clock with `hold` low after it was high zeroes the counter and drops `ready`. `ready` rises again at the edge that follows the counter reaching 2^(CNT_W-1). That same edge zeroes the counter. No watchdog pulse occurs during the wait.
- R11: A control write with `ctrl_we` high takes effect at the next edge. With `ctrl_we` low, `ctrl_wdata` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word: [4] watchdog enable, [3] full read, [2:0] tap select |
| clr | input | 1 | Clear command for the counter |
| hold | input | 1 | Power-save hold state of the core |
| tap_out | output | 1 | Selected divided output |
| rd_nibble | output | 4 | Counter readout nibble |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| ready | output | 1 | Low during the post-wake stabilisation wait |

## Verification
The bench builds a 9-bit counter. With this size, every tap setting including the two out-of-range codes can be combined with both read modes. Each combination runs for more than a full wrap, which shows whether the tap index and nibble slice are off by one bit and whether the coarse mode really masks the low bits. The watchdog is tried in three ways: left to expire repeatedly, fed with periodic clears, and cleared in the exact cycle it would fire. These separate the priority of clear over expiry. Hold sequences assert `clr` while frozen and then release. This shows the freeze, the wake restart, and that the stabilisation wait masks the watchdog.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int CTRL_W = 5;
  localparam int TAP_N  = 6;
  localparam int SEL_W  = 3;
  localparam int RD_W   = 4;

  typedef struct packed {
    logic             wdt_en;
    logic             full_read;
    logic [SEL_W-1:0] tap_sel;
  } ptw_ctrl_t;
endpackage

// File: rtl/ptw_ctrl_reg.sv
module ptw_ctrl_reg
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ptw_ctrl_t         ctrl
);
  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (we) ctrl <= ptw_ctrl_t'(wdata);
  end

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl)); // R11
endmodule

// File: rtl/ptw_counter.sv
module ptw_counter #(
  parameter int CNT_W  = 17,
  parameter int VIEW_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              clr,
  input  logic              wdt_en,
  output logic [VIEW_W-1:0] view,
  output logic              wdt_pulse,
  output logic              waiting
);
  localparam int TOP = CNT_W - 1;

  logic [CNT_W-1:0] cnt;
  logic             hold_q;
  logic             wake;
  logic             terminal;

  assign wake     = hold_q & ~hold;
  assign terminal = cnt[TOP];
  assign view     = cnt[TOP-1 -: VIEW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      waiting   <= 1'b0;
      wdt_pulse <= 1'b0;
      hold_q    <= hold;
    end else begin
      hold_q    <= hold;
      wdt_pulse <= 1'b0;
      if (!hold) begin
        if (wake) begin
          cnt     <= '0;
          waiting <= 1'b1;
        end else if (clr) begin
          cnt <= '0;
        end else if (terminal && waiting) begin
          cnt     <= '0;
          waiting <= 1'b0;
        end else if (terminal && wdt_en) begin
          cnt       <= '0;
          wdt_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(cnt)); // R9
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!hold && clr) |=> (cnt == '0)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr && !hold_q && !cnt[TOP]) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wdt_pulse |=> !wdt_pulse); // R7
  AST_NO_FIRE_WAIT: assert property (@(posedge clk) disable iff (rst)
    waiting |=> !wdt_pulse); // R10
  AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |=> (cnt == '0 && waiting)); // R10
endmodule

// File: rtl/ptw_readout.sv
module ptw_readout
  import ptw_pkg::*;
(
  input  logic [TAP_N-1:0] view,
  input  ptw_ctrl_t        ctrl,
  output logic             tap,
  output logic [RD_W-1:0]  rd
);
  localparam int SEL_N = 2 ** SEL_W;

  logic [SEL_N-1:0] tap_vec;

  for (genvar i = 0; i < SEL_N; i++) begin : g_tap
    localparam int OFS = (i < TAP_N) ? i : TAP_N - 1;
    assign tap_vec[i] = view[OFS];
  end

  assign tap = tap_vec[ctrl.tap_sel];
  assign rd  = ctrl.full_read ? view[TAP_N-1 -: RD_W]
                              : {view[TAP_N-1], {(RD_W-1){1'b0}}};

  always_comb begin
    if (!ctrl.full_read) AST_COARSE_LOW: assert (rd[RD_W-2:0] == '0); // R6
  end
endmodule

// File: rtl/presc_wdt_timer.sv
module presc_wdt_timer
  import ptw_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              clr,
  input  logic              hold,
  output logic              tap_out,
  output logic [RD_W-1:0]   rd_nibble,
  output logic              wdt_rst,
  output logic              ready
);
  ptw_ctrl_t        ctrl;
  logic [TAP_N-1:0] view;
  logic             waiting;

  ptw_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl_we),
    .wdata (ctrl_wdata),
    .ctrl  (ctrl)
  );

  ptw_counter #(.CNT_W(CNT_W), .VIEW_W(TAP_N)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .clr       (clr),
    .wdt_en    (ctrl.wdt_en),
    .view      (view),
    .wdt_pulse (wdt_rst),
    .waiting   (waiting)
  );

  ptw_readout u_rd (
    .view (view),
    .ctrl (ctrl),
    .tap  (tap_out),
    .rd   (rd_nibble)
  );

  assign ready = ~waiting;

  AST_READY_RESET: assert property (@(posedge clk) rst |=> ready); // R1
endmodule

// File: tb/presc_wdt_timer_tb_top.sv
module presc_wdt_timer_tb_top;
  localparam int CW = 9;
  localparam int N  = 2 ** (CW - 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [4:0] ctrl_wdata = '0;
  logic       clr = 1'b0;
  logic       hold = 1'b0;
  logic       tap_out;
  logic [3:0] rd_nibble;
  logic       wdt_rst;
  logic       ready;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;

  int       m  = 0;
  logic [4:0] mc = '0;
  bit       mw = 0;
  bit       mf = 0;
  bit       mh = 1;

  presc_wdt_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .clr(clr), .hold(hold), .tap_out(tap_out), .rd_nibble(rd_nibble),
    .wdt_rst(wdt_rst), .ready(ready)
  );

  always #10 clk = ~clk;

  task automatic check(input string ph, input string rq, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (phase %s) act=%0d exp=%0d at cycle %0d", rq, ph, act, exp, cyc);
    end
  endtask

  task automatic step(input string ph, input bit we, input logic [4:0] wd,
                      input bit c, input bit h, input bit r);
    int nm; bit nw; bit nf; int sel; int erd;
    ctrl_we = we; ctrl_wdata = wd; clr = c; hold = h; rst = r;
    @(posedge clk);
    if (r) begin
      m = 0; mc = '0; mw = 0; mf = 0; mh = h;
    end else begin
      nm = m; nw = mw; nf = 0;
      if (!h) begin
        if (mh)                  begin nm = 0; nw = 1; end
        else if (c)              nm = 0;
        else if (m >= N && mw)   begin nm = 0; nw = 0; end
        else if (m >= N && mc[4]) begin nm = 0; nf = 1; end
        else                     nm = (m + 1) % (2 * N);
      end
      if (we) mc = wd;
      m = nm; mw = nw; mf = nf; mh = h;
    end
    @(negedge clk);
    sel = (mc[2:0] > 5) ? 5 : int'(mc[2:0]);
    erd = mc[3] ? ((m >> (CW - 5)) & 15) : (((m >> (CW - 2)) & 1) << 3);
    check(ph, "R4", int'(tap_out), (m >> (CW - 7 + sel)) & 1);
    check(ph, mc[3] ? "R5" : "R6", int'(rd_nibble), erd);
    check(ph, mc[4] ? "R7" : "R8", int'(wdt_rst), int'(mf));
    check(ph, "R10", int'(ready), int'(!mw));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    step("R1", 0, '0, 0, 0, 1);
    step("R1", 1, 5'b11111, 1, 0, 1);
    // R2, R4, R5, R6: every tap code in both read modes, over a full wrap
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 2; f++) begin
        step("R2", 1, {1'b0, f[0], s[2:0]}, 1, 0, 0);
        for (int k = 0; k < 2 * N + 8; k++) step("R2", 0, '0, 0, 0, 0);
      end
    end
    // R11: strobe low with garbage data
    for (int k = 0; k < 20; k++) step("R11", 0, 5'b11111, 0, 0, 0);
    // R7: repeated expiry
    step("R7", 1, 5'b11011, 1, 0, 0);
    for (int k = 0; k < 3 * N; k++) step("R7", 0, '0, 0, 0, 0);
    // R3: periodic feeding, never expires
    step("R3", 1, 5'b11100, 1, 0, 0);
    for (int k = 1; k < 4 * N; k++) step("R3", 0, '0, (k % 200) == 0, 0, 0);
    // R3: clear in the exact expiry cycle
    step("R3", 0, '0, 1, 0, 0);
    while (m != N) step("R3", 0, '0, 0, 0, 0);
    step("R3", 0, '0, 1, 0, 0);
    for (int k = 0; k < 10; k++) step("R3", 0, '0, 0, 0, 0);
    // R9: hold freezes counter, clr ignored
    for (int k = 0; k < 40; k++) step("R9", 0, '0, k[0], 1, 0);
    // R10: wake wait masks watchdog, then resumes
    for (int k = 0; k < 2 * N + 20; k++) step("R10", 0, '0, 0, 0, 0);
    // R8: watchdog off, counter passes the threshold
    step("R8", 1, 5'b01010, 1, 0, 0);
    for (int k = 0; k < N + 40; k++) step("R8", 0, '0, 0, 0, 0);
    // R1: reset mid-run
    step("R1", 0, '0, 0, 0, 1);
    step("R1", 0, '0, 0, 0, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule